// File: doc/BRIEF.md
# Zone Line-State Tracker

This block keeps a 2-bit state for every cache line of one memory zone. A zone covers a power-of-two number of lines, 16 by default. The surrounding prefetcher writes the state of one line per cycle as demand accesses and prefetches happen. From the change between the line's stored state and the state written, the block produces one-cycle event pulses: a raw miss, an issued prefetch, a useful prefetch or a raw hit. A degree controller counts these pulses to estimate prefetch accuracy and coverage.

An initialise command sets every line of the zone to the INIT state in one cycle and produces no event. Several registered read ports let the prefetcher inspect line states while it searches for stride patterns. A write to a line that was never initialised is reported on an illegal-write flag.

Top module: `lzt_zone_tracker`

## Requirements
- R1: After synchronous reset every line reads INVALID and all event outputs are low. The state encoding is INIT=0, PREFETCH=1, ACCESS=2, INVALID=3.
- R2: A read port returns the state of `rd_idx` one cycle after it is presented. When a write to the same line falls in that cycle, the read returns the state held before the write. The written state is visible on the following read.
- R3: `init_en` sets every line to INIT (0) and produces no event. When `wr_en` is also high in that cycle, the write is discarded.
- R4: A write of PREFETCH (1) to a line holding INIT (0) pulses `ev_issue` in the next cycle.
- R5: A write of ACCESS (2) to a line holding INIT (0) pulses `ev_miss` in the next cycle.
- R6: A write of ACCESS (2) to a line holding PREFETCH (1) pulses `ev_good` in the next cycle.
- R7: A write of ACCESS (2) to a line holding ACCESS (2) pulses `ev_hit` in the next cycle.
- R8: Every other transition produces no event, and the written state is still stored. This covers a write of INIT (0) from any state, PREFETCH to PREFETCH, ACCESS to PREFETCH, and INIT to INVALID.
- R9: A write of a state other than INIT to a line holding INVALID (3) pulses `ev_illegal` in the next cycle and stores the written state. A write of INIT to an INVALID line raises no flag.
- R10: At most one of the five event outputs is high in any cycle. Each one lasts a single cycle and follows an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | Set the whole zone to INIT, no events |
| wr_en | input | 1 | Write one line's state |
| wr_idx | input | IW ($clog2(LINES)) | Line index of the write |
| wr_state | input | 2 | New state for the line |
| rd_idx | input | NRD*IW | Line index for each read port, port 0 in the low bits |
| rd_state | output | NRD*2 | Registered state for each read port, port 0 in the low bits |
| ev_issue | output | 1 | Prefetch issued (INIT to PREFETCH) |
| ev_miss | output | 1 | Raw miss (INIT to ACCESS) |
| ev_good | output | 1 | Useful prefetch (PREFETCH to ACCESS) |
| ev_hit | output | 1 | Raw hit (ACCESS to ACCESS) |
| ev_illegal | output | 1 | Non-INIT write to an INVALID line |

## Verification
Two pairs of functions can fall in the same cycle. The bench drives both on purpose.

The first pair is a read and a write to the same line. In one cycle the bench writes ACCESS to an INIT line while a read port addresses that line. It then expects the read to return INIT together with the miss pulse, and ACCESS one cycle later.

The second pair is the initialise command and a line write. The bench raises both in one cycle. It expects no event, and it expects both the targeted line and a line that previously held ACCESS to read back as INIT.

// File: rtl/lzt_pkg.sv
package lzt_pkg;

  typedef enum logic [1:0] {
    LS_INIT  = 2'd0,
    LS_PREF  = 2'd1,
    LS_ACC   = 2'd2,
    LS_INVAL = 2'd3
  } line_state_e;

  typedef struct packed {
    logic illegal;
    logic hit;
    logic good;
    logic miss;
    logic issue;
  } zone_evt_t;

endpackage

// File: rtl/lzt_state_store.sv
module lzt_state_store
  import lzt_pkg::*;
#(
  parameter int LINES = 16,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_en,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [1:0]        wr_state,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic [NRD*2-1:0]  rd_state,
  output logic [1:0]        wr_old
);

  // Register array: a single-cycle whole-zone initialise needs every cell.
  logic [1:0] cell_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) cell_q[i] <= LS_INVAL;
    end else if (init_en) begin
      for (int i = 0; i < LINES; i++) cell_q[i] <= LS_INIT;
    end else if (wr_en) begin
      cell_q[wr_idx] <= wr_state;
    end
  end

  // Old state of the addressed line, for the transition classifier.
  assign wr_old = cell_q[wr_idx];

  // Registered read ports, read-before-write.
  genvar p;
  generate
    for (p = 0; p < NRD; p++) begin : g_rd
      logic [1:0] rd_q;
      always_ff @(posedge clk) begin
        if (rst) rd_q <= LS_INVAL;
        else     rd_q <= cell_q[rd_idx[p*IW +: IW]];
      end
      assign rd_state[p*2 +: 2] = rd_q;
    end
  endgenerate

endmodule

// File: rtl/lzt_evt_classify.sv
module lzt_evt_classify
  import lzt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      valid,
  input  logic [1:0] old_state,
  input  logic [1:0] new_state,
  output zone_evt_t evt
);

  zone_evt_t evt_d, evt_q;

  always_comb begin
    evt_d = '0;
    if (valid && (new_state != LS_INIT)) begin
      unique case (old_state)
        LS_INIT: begin
          evt_d.issue = (new_state == LS_PREF);
          evt_d.miss  = (new_state == LS_ACC);
        end
        LS_PREF:  evt_d.good    = (new_state == LS_ACC);
        LS_ACC:   evt_d.hit     = (new_state == LS_ACC);
        default:  evt_d.illegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_d;
  end

  assign evt = evt_q;

endmodule

// File: rtl/lzt_zone_tracker.sv
module lzt_zone_tracker
  import lzt_pkg::*;
#(
  parameter int LINES = 16,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_en,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [1:0]        wr_state,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic [NRD*2-1:0]  rd_state,
  output logic              ev_issue,
  output logic              ev_miss,
  output logic              ev_good,
  output logic              ev_hit,
  output logic              ev_illegal
);

  logic [1:0] old_state;
  zone_evt_t  evt;
  logic       wr_accept;

  // The initialise command takes priority over a line write.
  assign wr_accept = wr_en && !init_en;

  lzt_state_store #(.LINES(LINES), .NRD(NRD)) u_store (
    .clk      (clk),
    .rst      (rst),
    .init_en  (init_en),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_state (wr_state),
    .rd_idx   (rd_idx),
    .rd_state (rd_state),
    .wr_old   (old_state)
  );

  lzt_evt_classify u_cls (
    .clk       (clk),
    .rst       (rst),
    .valid     (wr_accept),
    .old_state (old_state),
    .new_state (wr_state),
    .evt       (evt)
  );

  assign ev_issue   = evt.issue;
  assign ev_miss    = evt.miss;
  assign ev_good    = evt.good;
  assign ev_hit     = evt.hit;
  assign ev_illegal = evt.illegal;

endmodule

// File: rtl/lzt_zone_tracker_chk.sv
module lzt_zone_tracker_chk #(
  parameter int LINES = 16,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst,
  input logic              init_en,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx,
  input logic [1:0]        wr_state,
  input logic [NRD*IW-1:0] rd_idx,
  input logic [NRD*2-1:0]  rd_state,
  input logic              ev_issue,
  input logic              ev_miss,
  input logic              ev_good,
  input logic              ev_hit,
  input logic              ev_illegal
);

  logic [4:0] evs;
  assign evs = {ev_illegal, ev_hit, ev_good, ev_miss, ev_issue};

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (evs == 5'b0));

  a_r3_init_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(init_en) |-> (evs == 5'b0));

  a_r8_init_write_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && (wr_state == 2'd0)) |-> (evs == 5'b0));

  a_r4_issue_needs_pref: assert property (@(posedge clk) disable iff (rst)
    ev_issue |-> ($past(wr_state) == 2'd1));

  a_r5_r6_r7_access_events: assert property (@(posedge clk) disable iff (rst)
    (ev_miss || ev_good || ev_hit) |-> ($past(wr_state) == 2'd2));

  a_r9_illegal_not_init: assert property (@(posedge clk) disable iff (rst)
    ev_illegal |-> ($past(wr_state) != 2'd0));

  a_r10_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evs));

  a_r10_after_write: assert property (@(posedge clk) disable iff (rst)
    (evs != 5'b0) |-> $past(wr_en && !init_en));

endmodule

bind lzt_zone_tracker lzt_zone_tracker_chk #(.LINES(LINES), .NRD(NRD)) u_chk (.*);

// File: tb/lzt_zone_tracker_test.sv
`timescale 1ns/1ps
module lzt_zone_tracker_test;

  localparam int LINES = 16;
  localparam int NRD   = 2;
  localparam int IW    = $clog2(LINES);

  logic              clk = 1'b0;
  logic              rst;
  logic              init_en;
  logic              wr_en;
  logic [IW-1:0]     wr_idx;
  logic [1:0]        wr_state;
  logic [NRD*IW-1:0] rd_idx;
  logic [NRD*2-1:0]  rd_state;
  logic ev_issue, ev_miss, ev_good, ev_hit, ev_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  lzt_zone_tracker #(.LINES(LINES), .NRD(NRD)) uut (.*);

  function automatic logic [4:0] evs();
    return {ev_illegal, ev_hit, ev_good, ev_miss, ev_issue};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {idx[3:0], new state[1:0], expected {illegal,hit,good,miss,issue}}
  localparam logic [10:0] VEC [12] = '{
    {4'd3,  2'd1, 5'b00001},
    {4'd3,  2'd2, 5'b00100},
    {4'd3,  2'd2, 5'b01000},
    {4'd5,  2'd2, 5'b00010},
    {4'd5,  2'd1, 5'b00000},
    {4'd7,  2'd1, 5'b00001},
    {4'd7,  2'd1, 5'b00000},
    {4'd7,  2'd0, 5'b00000},
    {4'd7,  2'd2, 5'b00010},
    {4'd15, 2'd3, 5'b00000},
    {4'd15, 2'd2, 5'b10000},
    {4'd0,  2'd1, 5'b00001}
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; init_en = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_state = '0;
    rd_idx = {4'd9, 4'd0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 events after reset", int'(evs()), 0);
    chk("R1 port0 line0 INVALID", int'(rd_state[1:0]), 3);
    chk("R1 port1 line9 INVALID", int'(rd_state[3:2]), 3);

    // R9 / R8: INIT write on an INVALID line raises nothing
    wr_en = 1'b1; wr_idx = 4'd1; wr_state = 2'd0; rd_idx = {4'd9, 4'd1};
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 INIT write on INVALID no flag", int'(evs()), 0);
    @(negedge clk);
    chk("R8 INIT stored on line1", int'(rd_state[1:0]), 0);

    // R3: initialise zone
    init_en = 1'b1;
    @(negedge clk);
    init_en = 1'b0;
    chk("R3 init no events", int'(evs()), 0);

    // Table walk (R4 R5 R6 R7 R8 R9)
    for (int v = 0; v < 12; v++) begin
      wr_en = 1'b1; wr_idx = VEC[v][10:7]; wr_state = VEC[v][6:5];
      rd_idx = {4'd0, VEC[v][10:7]};
      @(negedge clk);
      wr_en = 1'b0;
      chk($sformatf("vector %0d events (R4 R5 R6 R7 R8 R9)", v),
          int'(evs()), int'(VEC[v][4:0]));
      @(negedge clk);
      chk($sformatf("vector %0d stored state (R2 R8 R9)", v),
          int'(rd_state[1:0]), int'(VEC[v][6:5]));
      chk($sformatf("vector %0d single pulse R10", v), int'(evs()), 0);
    end

    // R3: init and write together; line 3 holds ACCESS
    init_en = 1'b1; wr_en = 1'b1; wr_idx = 4'd4; wr_state = 2'd1;
    @(negedge clk);
    init_en = 1'b0; wr_en = 1'b0; rd_idx = {4'd4, 4'd3};
    chk("R3 collision no events", int'(evs()), 0);
    @(negedge clk);
    chk("R3 line3 INIT after init", int'(rd_state[1:0]), 0);
    chk("R3 line4 write dropped", int'(rd_state[3:2]), 0);

    // R2: read and write of the same line in one cycle
    wr_en = 1'b1; wr_idx = 4'd2; wr_state = 2'd2; rd_idx = {4'd2, 4'd0};
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 read returns old state", int'(rd_state[3:2]), 0);
    chk("R5 miss with same-cycle read", int'(evs()), 5'b00010);
    @(negedge clk);
    chk("R2 read returns new state", int'(rd_state[3:2]), 2);
    chk("R10 pulse ends", int'(evs()), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule